// File: doc/BRIEF.md
# Command-Register Interval Timer Bank

A bank of identical 32-bit interval timers behind a simple synchronous register bus. Each channel advances on its own tick-enable input, so one bank can serve a slow system tick (about 32.768 kHz), a millisecond tick and two microsecond timebases while every flop runs on one clock. The channel is driven by command addresses: a write of any value to the reset, start or stop address performs that action. Mode, terminal count and interrupt enable are written directly. A packed status word and the live count can be read back at any time.

A channel counts up from zero. When the count equals the terminal count, the next tick returns it to zero and sets a pending flag. In continuous mode the channel keeps running. In one-shot mode it stops itself and goes back to idle. Each channel drives its own interrupt line, which is high while the pending flag and the interrupt enable are both set. A shared one-bit clock-request register completes the map.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel status reads 0x01 (idle, stopped, continuous, interrupt disabled, nothing pending), every count reads 0, every terminal count reads 0xFFFFFFFF, all interrupt lines are low and the clock-request register and output are 0.
- R2: Channel n owns byte offsets n*0x40 to n*0x40+0x3F. Inside a window the offsets are 0x00 reset, 0x04 start, 0x08 stop, 0x0C mode, 0x10 status, 0x14 count, 0x18 terminal count, 0x1C interrupt enable and 0x20 acknowledge. The clock-request bit is bit 0 at 0x100 and drives clk_req_o.
- R3: A read of a write-only offset (reset, start, stop, mode, interrupt enable, acknowledge) or of an unmapped address returns 0. Read data appears on rdata_o one cycle after the read request.
- R4: A write to the start address sets the channel running and a write to the stop address halts it. The written data has no effect.
- R5: A write to the reset address clears the count and the pending flag and stops the channel. The terminal count, the mode and the interrupt enable keep their values.
- R6: A running channel increments its count by one on each cycle in which its own tick input is high. A stopped channel, or a cycle without its tick, leaves the count unchanged.
- R7: In continuous mode (mode bit 0 = 0), a tick that finds the count equal to the terminal count loads 0 and sets pending, and the channel keeps running.
- R8: In one-shot mode (mode bit 0 = 1), the same terminal tick also stops the channel, so its status returns to idle and the count stays at 0.
- R9: irq_o[n] is high exactly while channel n has pending set and interrupt enable (bit 0 of the enable register) set. A write to the acknowledge address with bit 7 set clears pending. An acknowledge write with bit 7 clear has no effect.
- R10: An acknowledge written in the same cycle as a terminal tick leaves pending set.
- R11: Status bits 3:0 hold 1 when stopped and 2 when running. Bit 4 is running, bit 5 is one-shot mode, bit 6 is interrupt enable and bit 7 is pending. The upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | NUM_CH | Per-channel count enable |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read request |
| irq_o | output | NUM_CH | Per-channel interrupt |
| clk_req_o | output | 1 | Clock-request control bit |

## Verification
An acknowledge write can arrive in the same cycle as the terminal tick that sets pending again. The bench first lets a terminal tick set pending. It then advances the channel to one tick short of the terminal count and issues the acknowledge write in the same clock as the terminal tick, with both driven from one task. It judges the result from the interrupt line and the returned count: the line must stay high and the count must have gone back to zero. A second coincidence, a reset command arriving on a ticking cycle, is covered by giving the reset priority, and a checker property guards it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW    = 32;
  localparam int WIN_W = 6;

  localparam logic [WIN_W-1:0] OFS_RST  = 6'h00;
  localparam logic [WIN_W-1:0] OFS_RUN  = 6'h04;
  localparam logic [WIN_W-1:0] OFS_STOP = 6'h08;
  localparam logic [WIN_W-1:0] OFS_MODE = 6'h0C;
  localparam logic [WIN_W-1:0] OFS_STAT = 6'h10;
  localparam logic [WIN_W-1:0] OFS_CNT  = 6'h14;
  localparam logic [WIN_W-1:0] OFS_TC   = 6'h18;
  localparam logic [WIN_W-1:0] OFS_IE   = 6'h1C;
  localparam logic [WIN_W-1:0] OFS_ACK  = 6'h20;

  localparam logic [3:0] ST_IDLE = 4'd1;
  localparam logic [3:0] ST_RUN  = 4'd2;
  localparam int         ACK_BIT = 7;

  typedef struct packed {
    logic rst;
    logic run;
    logic stop;
    logic mode;
    logic tc;
    logic ie;
    logic ack;
  } chan_wr_t;

  localparam int WR_W = $bits(chan_wr_t);
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output chan_wr_t          wr_o [NUM_CH],
  output logic              crc_we_o
);
  localparam int              CH_W     = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] CRC_ADDR = ADDR_W'(NUM_CH << WIN_W);

  logic            wr_en;
  logic [CH_W-1:0] ch;
  logic [WIN_W-1:0] ofs;

  assign wr_en    = req_i && we_i;
  assign ch       = addr_i[WIN_W +: CH_W];
  assign ofs      = addr_i[WIN_W-1:0];
  assign crc_we_o = wr_en && (addr_i == CRC_ADDR);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) wr_o[i] = '0;
    if (wr_en && (addr_i < CRC_ADDR)) begin
      unique case (ofs)
        OFS_RST:  wr_o[ch].rst  = 1'b1;
        OFS_RUN:  wr_o[ch].run  = 1'b1;
        OFS_STOP: wr_o[ch].stop = 1'b1;
        OFS_MODE: wr_o[ch].mode = 1'b1;
        OFS_TC:   wr_o[ch].tc   = 1'b1;
        OFS_IE:   wr_o[ch].ie   = 1'b1;
        OFS_ACK:  wr_o[ch].ack  = 1'b1;
        default:  ;
      endcase
    end
  end

  logic [NUM_CH*WR_W-1:0] wr_flat;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign wr_flat[g*WR_W +: WR_W] = wr_o[g];
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_flat, crc_we_o}));

  // R2
  strobe_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_flat) |-> (req_i && we_i && !crc_we_o));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  chan_wr_t      wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] tc_o,
  output logic          irq_o
);
  logic          run_q, one_q, ie_q, pend_q;
  logic [DW-1:0] cnt_q, tc_q;
  logic          adv, hit, ack_ok;

  assign adv    = run_q && tick_i;
  assign hit    = adv && (cnt_q == tc_q);
  assign ack_ok = wr_i.ack && wdata_i[ACK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      one_q  <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      tc_q   <= '1;
    end else begin
      if (wr_i.mode) one_q <= wdata_i[0];
      if (wr_i.ie)   ie_q  <= wdata_i[0];
      if (wr_i.tc)   tc_q  <= wdata_i;
      if (wr_i.rst) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
        run_q  <= 1'b0;
      end else begin
        if (adv) cnt_q <= hit ? '0 : cnt_q + 1'b1;
        // a new hit outranks a same-cycle acknowledge
        if (hit)         pend_q <= 1'b1;
        else if (ack_ok) pend_q <= 1'b0;
        if (wr_i.stop)          run_q <= 1'b0;
        else if (wr_i.run)      run_q <= 1'b1;
        else if (hit && one_q)  run_q <= 1'b0;
      end
    end
  end

  assign status_o = {{(DW-8){1'b0}}, pend_q, ie_q, one_q, run_q,
                     run_q ? ST_RUN : ST_IDLE};
  assign cnt_o    = cnt_q;
  assign tc_o     = tc_q;
  assign irq_o    = pend_q && ie_q;

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(status_o[4] && tick_i) && !wr_i.rst) |=> $stable(cnt_o));

  // R7
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && tick_i && (cnt_o == tc_o) && !wr_i.rst)
      |=> (cnt_o == '0) && status_o[7]);

  // R8
  one_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && status_o[5] && tick_i && (cnt_o == tc_o) && !wr_i.rst && !wr_i.run)
      |=> !status_o[4] && (status_o[3:0] == ST_IDLE));

  // R5
  rst_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i.rst |=> (cnt_o == '0) && !status_o[7] && !status_o[4]
                 && (tc_o == $past(tc_o)) && (status_o[6] == $past(status_o[6])));

  // R10
  ack_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_i.ack && !wr_i.rst) |=> status_o[7]);

  // R9
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[7]) |-> $past(ack_ok || wr_i.rst));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              clk_req_o
);
  localparam int                CH_W     = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] CRC_ADDR = ADDR_W'(NUM_CH << WIN_W);

  chan_wr_t      wr [NUM_CH];
  logic          crc_we;
  logic          crc_q;
  logic [DW-1:0] st  [NUM_CH];
  logic [DW-1:0] cnt [NUM_CH];
  logic [DW-1:0] tc  [NUM_CH];
  logic [DW-1:0] rd_d, rd_q;
  logic [CH_W-1:0] rd_ch;

  tmr_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_o     (wr),
    .crc_we_o (crc_we)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i[g]),
      .wr_i     (wr[g]),
      .wdata_i  (wdata_i),
      .status_o (st[g]),
      .cnt_o    (cnt[g]),
      .tc_o     (tc[g]),
      .irq_o    (irq_o[g])
    );
  end

  assign rd_ch = addr_i[WIN_W +: CH_W];

  always_comb begin
    rd_d = '0;
    if (addr_i == CRC_ADDR) begin
      rd_d = {{(DW-1){1'b0}}, crc_q};
    end else if (addr_i < CRC_ADDR) begin
      unique case (addr_i[WIN_W-1:0])
        OFS_STAT: rd_d = st[rd_ch];
        OFS_CNT:  rd_d = cnt[rd_ch];
        OFS_TC:   rd_d = tc[rd_ch];
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (crc_we) crc_q <= wdata_i[0];
      rd_q <= (req_i && !we_i) ? rd_d : '0;
    end
  end

  assign rdata_o   = rd_q;
  assign clk_req_o = crc_q;

  // R3
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i > CRC_ADDR)) |=> (rdata_o == '0));

  // R2
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_we |=> $stable(clk_req_o));
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 9;
  localparam int NV     = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] tick = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] irq;
  logic              clk_req;

  int  nchk = 0, nfail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_tmr_bank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .clk_req_o(clk_req)
  );

  // {req tag, write, addr, wdata, expected read}
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  1'b0, 9'h010, 32'h0,        32'h0000_0001}, // R1 ch0 status
    {4'd1,  1'b0, 9'h0D4, 32'h0,        32'h0000_0000}, // R1 ch3 count
    {4'd1,  1'b0, 9'h098, 32'h0,        32'hFFFF_FFFF}, // R1 ch2 terminal
    {4'd1,  1'b0, 9'h100, 32'h0,        32'h0000_0000}, // R1 clock request
    {4'd2,  1'b1, 9'h100, 32'h1,        32'h0},
    {4'd2,  1'b0, 9'h100, 32'h0,        32'h0000_0001}, // R2
    {4'd2,  1'b1, 9'h058, 32'h1234,     32'h0},
    {4'd2,  1'b0, 9'h058, 32'h0,        32'h0000_1234}, // R2 ch1 window
    {4'd2,  1'b0, 9'h018, 32'h0,        32'hFFFF_FFFF}, // R2 ch0 untouched
    {4'd3,  1'b0, 9'h00C, 32'h0,        32'h0000_0000}, // R3 write-only
    {4'd3,  1'b0, 9'h1FC, 32'h0,        32'h0000_0000}, // R3 unmapped
    {4'd11, 1'b1, 9'h04C, 32'h1,        32'h0},
    {4'd11, 1'b1, 9'h05C, 32'h1,        32'h0},
    {4'd11, 1'b0, 9'h050, 32'h0,        32'h0000_0061}, // R11
    {4'd4,  1'b1, 9'h044, 32'hDEADBEEF, 32'h0},
    {4'd4,  1'b0, 9'h050, 32'h0,        32'h0000_0072}, // R4 start
    {4'd4,  1'b1, 9'h048, 32'h0,        32'h0},
    {4'd4,  1'b0, 9'h050, 32'h0,        32'h0000_0061}, // R4 stop
    {4'd4,  1'b1, 9'h0C4, 32'h0,        32'h0},
    {4'd4,  1'b0, 9'h0D0, 32'h0,        32'h0000_0012}  // R4 ch3 start
  };

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d,
                    input logic [NUM_CH-1:0] tk = '0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string r, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(r, v, exp);
  endtask

  task automatic ticks(input logic [NUM_CH-1:0] m, input int n);
    repeat (n) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = '0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {28'h0, irq}, 32'h0);
    check("R1 clk_req", {31'h0, clk_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      if (VEC[i][73]) wr(VEC[i][72:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][72:64], v);
        check($sformatf("R%0d vector %0d", VEC[i][77:74], i), v, VEC[i][31:0]);
      end
    end
    check("R2 clk_req pin", {31'h0, clk_req}, 32'h1);

    // continuous run on ch0, terminal count 3
    wr(9'h018, 32'd3); wr(9'h01C, 32'd1); wr(9'h004, 32'd0);
    ticks(4'b0010, 5);
    rdchk("R6 foreign tick", 9'h014, 32'd0);
    ticks(4'b0001, 2);
    rdchk("R6 count", 9'h014, 32'd2);
    ticks(4'b0001, 2);
    check("R7 irq", {28'h0, irq}, 32'h1);
    rdchk("R7 wrap", 9'h014, 32'd0);
    rdchk("R11 status", 9'h010, 32'h0000_00D2);

    wr(9'h020, 32'h7F);
    check("R9 ack bit7 clear", {28'h0, irq}, 32'h1);
    wr(9'h020, 32'h80);
    check("R9 ack", {28'h0, irq}, 32'h0);
    rdchk("R9 status", 9'h010, 32'h0000_0052);

    // pending again, then acknowledge on the terminal tick
    ticks(4'b0001, 4);
    check("R7 second hit", {28'h0, irq}, 32'h1);
    ticks(4'b0001, 3);
    wr(9'h020, 32'h80, 4'b0001);
    check("R10 irq", {28'h0, irq}, 32'h1);
    rdchk("R10 count", 9'h014, 32'd0);

    ticks(4'b0001, 2);
    wr(9'h000, 32'h55);
    rdchk("R5 count", 9'h014, 32'd0);
    rdchk("R5 status", 9'h010, 32'h0000_0041);
    rdchk("R5 terminal", 9'h018, 32'd3);
    check("R5 irq", {28'h0, irq}, 32'h0);

    wr(9'h00C, 32'd1); wr(9'h004, 32'd0);
    ticks(4'b0001, 4);
    rdchk("R8 status", 9'h010, 32'h0000_00E1);
    ticks(4'b0001, 2);
    rdchk("R8 stopped", 9'h014, 32'd0);

    wr(9'h01C, 32'd0);
    check("R9 ie off", {28'h0, irq}, 32'h0);
    rdchk("R9 pend kept", 9'h010, 32'h0000_00A1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule